// File: doc/BRIEF.md
# Converter Serial Port with Read Abort

This block is the digital serial port of a sampling converter. A down-counter stands in for the conversion. When the count expires, the busy flag drops and a 32-bit result word is built from a parallel sample input. The host lowers chip select and clocks the word out on an external serial clock, most significant bit first. On the same clock edges it shifts a configuration code into the port on the serial data input.

Raising chip select ends the read and starts the next conversion. This also works part-way through the word. The configuration code shifted in during that read is kept only if enough clock edges arrived before the abort. Otherwise the previous setting stays in force.

Chip select, serial clock and serial data are brought into the system clock domain through two-stage synchronizers. All edges are detected in that domain.

Top module: `adc_serial_port`

## Requirements
- R1: After reset, `cfg_o` equals `CFG_RESET` (all zero by default), a conversion runs at once, and `busy_o` is high for exactly `CONV_CYCLES` system clock cycles before it drops.
- R2: `sdo_oe_o` is high exactly while `cs_ni` is low. While a conversion runs, `sdo_o` is 1, which shows that no result is ready.
- R3: When a conversion ends, `busy_o` goes low and `sdo_o` goes to 0 before any serial clock edge arrives.
- R4: The output word is, from bit 31 down: bit 31 = 0 (the inverted ready flag), bit 30 = 0, bits 29..0 = `sample_i[29:0]` captured at the end of the conversion (bit 29 is the sign). Bit 31 is on `sdo_o` as soon as chip select is low. Each falling serial clock edge advances the output by one bit.
- R5: `sdi_i` is sampled on rising serial clock edges. The first 13 samples form the new configuration code, first bit at bit 12. If chip select rises after at least 14 falling edges (the full 32 included), the code is copied to `cfg_o` and a new conversion starts.
- R6: If chip select rises after 5 to 13 falling edges, a new conversion starts and `cfg_o` keeps its previous value.
- R7: If chip select rises after fewer than 5 falling edges, no conversion starts and the result is kept. The next read starts again at bit 31.
- R8: Serial clock edges have no effect on the output position or on the configuration code while chip select is high or a conversion runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Chip select, active low (asynchronous) |
| sclk_i | input | 1 | External serial clock (asynchronous) |
| sdi_i | input | 1 | Serial configuration input |
| sample_i | input | 30 | Parallel result: sign in bit 29, magnitude below |
| sdo_o | output | 1 | Serial data / status output |
| sdo_oe_o | output | 1 | Output enable for `sdo_o`; low means high impedance |
| busy_o | output | 1 | High while a conversion runs |
| cfg_o | output | 13 | Configuration code in force for conversions |

## Verification
The bench aborts reads at exactly 13 and 14 falling edges, the two sides of the commit threshold. An off-by-one in that comparison either commits a partial code or throws away a valid one, and the bench sees it as a wrong `cfg_o`. A read cut off after 4 edges must leave the result intact and replay from bit 31. A design that starts a conversion there raises busy or emits a shifted word. Serial clock toggling with chip select high or during a conversion is followed by a full read, so a design that counts those edges shifts the word or corrupts the committed code.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;
  localparam int WORD_W   = 32;
  localparam int SAMPLE_W = WORD_W - 2;
  localparam int FC_W     = $clog2(WORD_W + 1);
endpackage

// File: rtl/adc_sp_sync.sv
module adc_sp_sync #(
  parameter int             W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [1:0] ff;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff <= {2{RST_VAL[b]}};
      else         ff <= {ff[0], d_i[b]};
    end
    assign q_o[b] = ff[1];
  end
endmodule

// File: rtl/adc_sp_conv_timer.sv
module adc_sp_conv_timer #(
  parameter int CONV_CYCLES = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = (CONV_CYCLES > 2) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(CONV_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b1;
      cnt_q <= LOAD;
    end else if (start_i) begin
      run_q <= 1'b1;
      cnt_q <= LOAD;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o = run_q;
  assign done_o = run_q && (cnt_q == '0);
endmodule

// File: rtl/adc_sp_frame.sv
module adc_sp_frame
  import adc_sp_pkg::*;
#(
  parameter int             CFG_W      = 13,
  parameter int             ABORT_MIN  = 5,
  parameter int             COMMIT_MIN = 14,
  parameter logic [CFG_W-1:0] CFG_RESET = '0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                busy_i,
  input  logic                done_i,
  input  logic                cs_low_i,
  input  logic                cs_rise_i,
  input  logic                sclk_rise_i,
  input  logic                sclk_fall_i,
  input  logic                sdi_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic                start_o,
  output logic                sdo_o,
  output logic [CFG_W-1:0]    cfg_o
);
  localparam int RC_W = $clog2(CFG_W + 1);
  localparam logic [FC_W-1:0] ABORT_AT  = FC_W'(ABORT_MIN);
  localparam logic [FC_W-1:0] COMMIT_AT = FC_W'(COMMIT_MIN);
  localparam logic [FC_W-1:0] WORD_LIM  = FC_W'(WORD_W);
  localparam logic [RC_W-1:0] CFG_LIM   = RC_W'(CFG_W);

  logic [WORD_W-1:0] word_q, word_sh;
  logic [FC_W-1:0]   fall_q;
  logic [RC_W-1:0]   rise_q;
  logic [CFG_W-1:0]  cfg_sh_q, cfg_q;
  logic              active, frame_end;

  assign active    = !busy_i && cs_low_i;
  assign frame_end = !busy_i && cs_rise_i;
  assign start_o   = frame_end && (fall_q >= ABORT_AT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q   <= '0;
      fall_q   <= '0;
      rise_q   <= '0;
      cfg_sh_q <= '0;
      cfg_q    <= CFG_RESET;
    end else if (done_i) begin
      word_q   <= {2'b00, sample_i};
      fall_q   <= '0;
      rise_q   <= '0;
      cfg_sh_q <= '0;
    end else if (frame_end) begin
      if (fall_q >= COMMIT_AT) cfg_q <= cfg_sh_q;
      fall_q   <= '0;
      rise_q   <= '0;
      cfg_sh_q <= '0;
    end else if (active) begin
      if (sclk_fall_i && fall_q < WORD_LIM) fall_q <= fall_q + 1'b1;
      if (sclk_rise_i && rise_q < CFG_LIM) begin
        rise_q   <= rise_q + 1'b1;
        cfg_sh_q <= {cfg_sh_q[CFG_W-2:0], sdi_i};
      end
    end
  end

  // shifting past the last bit leaves zero on the line
  assign word_sh = word_q << fall_q;
  assign sdo_o   = busy_i ? 1'b1 : word_sh[WORD_W-1];
  assign cfg_o   = cfg_q;
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
  import adc_sp_pkg::*;
#(
  parameter int               CONV_CYCLES = 256,
  parameter int               CFG_W       = 13,
  parameter int               ABORT_MIN   = 5,
  parameter int               COMMIT_MIN  = 14,
  parameter logic [CFG_W-1:0] CFG_RESET   = '0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cs_ni,
  input  logic                sclk_i,
  input  logic                sdi_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic                sdo_o,
  output logic                sdo_oe_o,
  output logic                busy_o,
  output logic [CFG_W-1:0]    cfg_o
);
  logic [2:0] pins_s;
  logic       cs_s, sclk_s, sdi_s;
  logic       cs_q, sclk_q;
  logic       start, done, busy;

  adc_sp_sync #(.W(3), .RST_VAL(3'b100)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sclk_i, sdi_i}),
    .q_o   (pins_s)
  );
  assign {cs_s, sclk_s, sdi_s} = pins_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      cs_q   <= cs_s;
      sclk_q <= sclk_s;
    end
  end

  adc_sp_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .busy_o (busy),
    .done_o (done)
  );

  adc_sp_frame #(
    .CFG_W     (CFG_W),
    .ABORT_MIN (ABORT_MIN),
    .COMMIT_MIN(COMMIT_MIN),
    .CFG_RESET (CFG_RESET)
  ) i_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .busy_i     (busy),
    .done_i     (done),
    .cs_low_i   (!cs_s),
    .cs_rise_i  (cs_s && !cs_q),
    .sclk_rise_i(sclk_s && !sclk_q),
    .sclk_fall_i(!sclk_s && sclk_q),
    .sdi_i      (sdi_s),
    .sample_i   (sample_i),
    .start_o    (start),
    .sdo_o      (sdo_o),
    .cfg_o      (cfg_o)
  );

  assign sdo_oe_o = !cs_ni;
  assign busy_o   = busy;
endmodule

// File: rtl/adc_serial_port_chk.sv
module adc_serial_port_chk #(
  parameter int CFG_W = 13
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sdo_o,
  input logic             sdo_oe_o,
  input logic             busy_o,
  input logic [CFG_W-1:0] cfg_o
);
  // R2: status bit reads 1 while a conversion runs
  p_status_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && sdo_oe_o |-> sdo_o);

  // R3: result ready shows 0 on the line
  p_ready_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !sdo_o);

  // R1: a started conversion lasts more than one cycle
  p_busy_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |=> busy_o);

  // R5: configuration only changes as a conversion starts
  p_cfg_at_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_o) |-> $rose(busy_o));

  // R6: configuration stays put during a conversion
  p_cfg_stable_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(cfg_o));
endmodule

bind adc_serial_port adc_serial_port_chk #(.CFG_W(CFG_W)) i_chk (.*);

// File: tb/test_adc_serial_port.sv
module test_adc_serial_port;
  localparam int CONV = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b0;
  logic        sdi = 1'b0;
  logic [29:0] sample = '0;
  logic        sdo, sdo_oe, busy;
  logic [12:0] cfg;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;
  string cur_req = "";
  logic exp_q[$];
  event smp_e;

  always #5 clk = ~clk;

  adc_serial_port #(.CONV_CYCLES(CONV)) i_adc_serial_port (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .cs_ni   (cs_n),
    .sclk_i  (sclk),
    .sdi_i   (sdi),
    .sample_i(sample),
    .sdo_o   (sdo),
    .sdo_oe_o(sdo_oe),
    .busy_o  (busy),
    .cfg_o   (cfg)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  // monitor: compares each serial bit against the scoreboard
  initial begin
    forever begin
      @(smp_e);
      if (exp_q.size() == 0) chk(1'b0, cur_req, 32'(sdo), 32'hx);
      else begin
        logic e;
        e = exp_q.pop_front();
        chk(sdo === e, cur_req, 32'(sdo), 32'(e));
      end
    end
  end

  task automatic ncyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_ready(input string req);
    int k = 0;
    while (busy && k < CONV + 20) begin
      @(negedge clk);
      k++;
    end
    chk(busy == 1'b0, req, 32'(busy), 32'd0);
  endtask

  task automatic clk_pulse(input logic d);
    sdi = d;
    sclk = 1'b1;
    ncyc(4);
    sclk = 1'b0;
    ncyc(4);
  endtask

  // driver: one read of nfall falling edges, shifting cfg in
  task automatic frame(input int nfall, input logic [12:0] c, input logic [31:0] w, input string req);
    cur_req = req;
    cs_n = 1'b0;
    ncyc(4);
    chk(sdo_oe == 1'b1, "R2", 32'(sdo_oe), 32'd1);
    for (int i = 0; i < nfall; i++) begin
      exp_q.push_back(w[31-i]);
      ->smp_e;
      @(negedge clk);
      clk_pulse(i < 13 ? c[12-i] : 1'b0);
    end
    cs_n = 1'b1;
    ncyc(6);
    chk(exp_q.size() == 0, req, 32'(exp_q.size()), 32'd0);
  endtask

  initial begin
    logic [31:0] wa, wb;
    wa = {2'b00, 30'h2ABC_DE12};
    wb = {2'b00, 30'h1555_0F0F};
    sample = 30'h2ABC_DE12;
    ncyc(3);
    rst_n = 1'b1;

    // R1: reset state and conversion length
    chk(busy == 1'b1, "R1", 32'(busy), 32'd1);
    chk(cfg == 13'h0, "R1", 32'(cfg), 32'd0);
    chk(sdo_oe == 1'b0, "R2", 32'(sdo_oe), 32'd0);
    // R2: status during conversion
    cs_n = 1'b0;
    ncyc(10);
    chk(sdo_oe == 1'b1, "R2", 32'(sdo_oe), 32'd1);
    chk(sdo == 1'b1, "R2", 32'(sdo), 32'd1);
    // R8: clocks during a conversion do nothing
    for (int i = 0; i < 4; i++) clk_pulse(1'b1);
    chk(sdo == 1'b1, "R8", 32'(sdo), 32'd1);
    ncyc(CONV - 10 - 32 - 4);
    chk(busy == 1'b1, "R1", 32'(busy), 32'd1);
    ncyc(6);
    chk(busy == 1'b0, "R1", 32'(busy), 32'd0);
    // R3: ready shows 0 with chip select still low
    chk(sdo == 1'b0, "R3", 32'(sdo), 32'd0);
    cs_n = 1'b1;
    ncyc(6);
    chk(sdo_oe == 1'b0, "R2", 32'(sdo_oe), 32'd0);

    // R4/R5: full 32-bit read commits the code
    frame(32, 13'h1A5C, wa, "R4");
    chk(busy == 1'b1, "R5", 32'(busy), 32'd1);
    chk(cfg == 13'h1A5C, "R5", 32'(cfg), 32'h1A5C);
    wait_ready("R3");

    // R6: abort after 10 edges keeps old code
    sample = 30'h1555_0F0F;
    frame(10, 13'h0F0F, wa, "R6");
    chk(busy == 1'b1, "R6", 32'(busy), 32'd1);
    chk(cfg == 13'h1A5C, "R6", 32'(cfg), 32'h1A5C);
    wait_ready("R3");

    // R5 boundary: 14 edges commits
    frame(14, 13'h0333, wb, "R4");
    chk(busy == 1'b1, "R5", 32'(busy), 32'd1);
    chk(cfg == 13'h0333, "R5", 32'(cfg), 32'h0333);
    wait_ready("R3");

    // R6 boundary: 13 edges does not commit
    frame(13, 13'h1111, wb, "R6");
    chk(busy == 1'b1, "R6", 32'(busy), 32'd1);
    chk(cfg == 13'h0333, "R6", 32'(cfg), 32'h0333);
    wait_ready("R3");

    // R7: 4 edges then chip select high: no restart, replay from bit 31
    sample = 30'h2ABC_DE12;
    frame(4, 13'h1F00, wb, "R7");
    chk(busy == 1'b0, "R7", 32'(busy), 32'd0);
    chk(cfg == 13'h0333, "R7", 32'(cfg), 32'h0333);
    frame(32, 13'h1555, wb, "R7");
    chk(cfg == 13'h1555, "R7", 32'(cfg), 32'h1555);
    wait_ready("R3");

    // R8: clocks with chip select high are ignored
    for (int i = 0; i < 8; i++) clk_pulse(1'b1);
    chk(sdo_oe == 1'b0, "R8", 32'(sdo_oe), 32'd0);
    frame(32, 13'h0A0A, wa, "R8");
    chk(cfg == 13'h0A0A, "R8", 32'(cfg), 32'h0A0A);
    wait_ready("R3");

    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    finish_run();
  end
endmodule